// File: doc/BRIEF.md
# Parallel Turbo Interleaver Address Generator

This block produces the scrambled couple addresses of a double-binary turbo code interleaver, one per clock, for a decoder built from several soft-in soft-out engines that share one set of banked memories. For each couple index j, running from zero up to the frame size minus one, it emits the interleaved index together with a flag marking couples whose two bits trade places. It computes the address by running sums and conditional subtraction alone, so no multiplier or divider is needed.

Each address is also split for a P-way banked memory. The frame is divided into P equal segments. The segment number picks the bank of engine 0, the offset inside the segment is a row address shared by all engines, and engine k reads bank (segment + k) mod P. The block picks P from the frame size as 1, 2 or 4. Because P is a power of two, every lane map is a rotation, so no two engines ever hit the same bank in a cycle.

A one-cycle `start` pulse captures the frame size, the step constant and four offset constants, then the block runs through the whole frame without stopping.

Top module: `ilv_addr_gen`

## Requirements
- R1: For j = 0 to N−1, in that order and one per cycle, `addrOut` equals (P0·j + C[j mod 4]) mod N. Here C0..C3 are `offs0`..`offs3`, and P0 and every Ck must be below N.
- R2: `validOut` first rises 2 clock cycles after the edge that samples `start`, then stays high for exactly N consecutive cycles and falls.
- R3: `swapOut` is 1 for odd j and 0 for even j.
- R4: The parallelism is P = 1 for N < 192, P = 2 for 192 ≤ N < 480 and P = 4 for N ≥ 480. N must be a multiple of P.
- R5: `rowOut` equals addrOut − q·(N/P), where q = floor(addrOut/(N/P)). It is therefore always below N/P.
- R6: Lane k of `bankIdx`, at bits [2k+1:2k], equals (q + k) mod P for k = 0..3. The lanes belonging to the P active engines name P distinct banks.
- R7: A `start` pulse that arrives while a frame is still being generated is ignored. Changes to the configuration inputs after capture do not affect the running frame.
- R8: After reset, `validOut`, `addrOut`, `swapOut`, `rowOut` and `bankIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and begin a frame |
| nCouples | input | 12 | Frame size N in couples |
| stepP0 | input | 12 | Step constant P0, below N |
| offs0 | input | 12 | Offset for j mod 4 = 0, below N |
| offs1 | input | 12 | Offset for j mod 4 = 1, below N |
| offs2 | input | 12 | Offset for j mod 4 = 2, below N |
| offs3 | input | 12 | Offset for j mod 4 = 3, below N |
| validOut | output | 1 | Output fields carry couple j |
| addrOut | output | 12 | Interleaved couple index |
| swapOut | output | 1 | Swap the two bits of this couple |
| rowOut | output | 12 | Row address common to all engines |
| bankIdx | output | 8 | Bank index per engine, 2 bits per lane |

## Verification
The hardest conditions to reach are the points where the running sums cross N. These include a step whose sum lands exactly on N, and an offset that pushes a value just over N on the final couple. The other hard condition is a segment boundary at each of the three frame sizes where P changes. The stimulus runs whole frames at N = 180, 192, 240, 480, 960 and 2400, plus a small N = 24 frame. It uses large step and offset constants, so every frame wraps the accumulator many times. It also drops a second `start` with a changed step constant into the middle of one frame, to show the running frame is left alone.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } ilvStrobe_t;
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] nCouples,
  output ilvStrobe_t    strobe,
  output logic [1:0]    jLow
);
  logic          running;
  logic [AW-1:0] jCnt;
  logic [AW-1:0] lastJ;

  always_comb begin
    strobe.load = start & ~running;
    strobe.step = running;
    jLow        = jCnt[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      jCnt    <= '0;
      lastJ   <= '0;
    end else if (strobe.load) begin
      running <= 1'b1;
      jCnt    <= '0;
      lastJ   <= nCouples - AW'(1);
    end else if (running) begin
      if (jCnt == lastJ) running <= 1'b0;
      jCnt <= jCnt + AW'(1);
    end
  end
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int AW    = 12,
  parameter int PMAX  = 4,
  parameter int P2MIN = 192,
  parameter int P4MIN = 480,
  localparam int LW   = $clog2(PMAX),
  localparam int PNW  = LW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ilvStrobe_t       strobe,
  input  logic [1:0]       jLow,
  input  logic [AW-1:0]    nCouples,
  input  logic [AW-1:0]    stepP0,
  input  logic [AW-1:0]    offs0,
  input  logic [AW-1:0]    offs1,
  input  logic [AW-1:0]    offs2,
  input  logic [AW-1:0]    offs3,
  output logic             validOut,
  output logic [AW-1:0]    addrOut,
  output logic             swapOut,
  output logic [AW-1:0]    rowOut,
  output logic [PMAX*LW-1:0] bankIdx
);
  logic [AW-1:0] nReg, stepReg, acc;
  logic [AW-1:0] offsReg [4];
  logic [LW-1:0] pLogReg, pLogNew;

  // stage 1 registers
  logic          s1Valid, s1Swap;
  logic [AW-1:0] s1Addr;

  // configuration capture
  always_comb begin
    if (nCouples >= AW'(P4MIN))      pLogNew = LW'(2);
    else if (nCouples >= AW'(P2MIN)) pLogNew = LW'(1);
    else                             pLogNew = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nReg    <= '0;
      stepReg <= '0;
      pLogReg <= '0;
      for (int k = 0; k < 4; k++) offsReg[k] <= '0;
    end else if (strobe.load) begin
      nReg       <= nCouples;
      stepReg    <= stepP0;
      pLogReg    <= pLogNew;
      offsReg[0] <= offs0;
      offsReg[1] <= offs1;
      offsReg[2] <= offs2;
      offsReg[3] <= offs3;
    end
  end

  // stage 1: running product and offset, each folded by one subtraction
  logic [AW:0]   accSum, addSum;
  logic [AW-1:0] accNext, addrNow;

  always_comb begin
    accSum  = {1'b0, acc} + {1'b0, stepReg};
    accNext = (accSum >= {1'b0, nReg}) ? AW'(accSum - {1'b0, nReg}) : accSum[AW-1:0];
    addSum  = {1'b0, acc} + {1'b0, offsReg[jLow]};
    addrNow = (addSum >= {1'b0, nReg}) ? AW'(addSum - {1'b0, nReg}) : addSum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      s1Valid <= 1'b0;
      s1Swap  <= 1'b0;
      s1Addr  <= '0;
    end else begin
      s1Valid <= strobe.step;
      if (strobe.load) acc <= '0;
      else if (strobe.step) begin
        acc    <= accNext;
        s1Addr <= addrNow;
        s1Swap <= jLow[0];
      end
    end
  end

  // stage 2: segment split by shifted thresholds
  logic [AW-1:0]  segLen, baseSel, rowNow;
  logic [AW-1:0]  thr [PMAX];
  logic [PNW-1:0] pNum;
  logic [LW-1:0]  pMask, segSel;
  logic [LW-1:0]  laneNow [PMAX];

  assign segLen = nReg >> pLogReg;
  assign pNum   = PNW'(1) << pLogReg;
  assign pMask  = LW'(pNum - PNW'(1));
  assign thr[0] = '0;

  for (genvar g = 1; g < PMAX; g++) begin : g_thr
    assign thr[g] = thr[g-1] + segLen;
  end

  always_comb begin
    segSel  = '0;
    baseSel = '0;
    for (int k = 1; k < PMAX; k++) begin
      if (PNW'(k) < pNum && s1Addr >= thr[k]) begin
        segSel  = LW'(k);
        baseSel = thr[k];
      end
    end
    rowNow = s1Addr - baseSel;
  end

  for (genvar g = 0; g < PMAX; g++) begin : g_lane
    assign laneNow[g] = (segSel + LW'(g)) & pMask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validOut <= 1'b0;
      addrOut  <= '0;
      swapOut  <= 1'b0;
      rowOut   <= '0;
      bankIdx  <= '0;
    end else begin
      validOut <= s1Valid;
      if (s1Valid) begin
        addrOut <= s1Addr;
        swapOut <= s1Swap;
        rowOut  <= rowNow;
        for (int k = 0; k < PMAX; k++) bankIdx[k*LW +: LW] <= laneNow[k];
      end
    end
  end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int AW    = 12,
  parameter int PMAX  = 4,
  parameter int P2MIN = 192,
  parameter int P4MIN = 480,
  localparam int LW   = $clog2(PMAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       nCouples,
  input  logic [AW-1:0]       stepP0,
  input  logic [AW-1:0]       offs0,
  input  logic [AW-1:0]       offs1,
  input  logic [AW-1:0]       offs2,
  input  logic [AW-1:0]       offs3,
  output logic                validOut,
  output logic [AW-1:0]       addrOut,
  output logic                swapOut,
  output logic [AW-1:0]       rowOut,
  output logic [PMAX*LW-1:0]  bankIdx
);
  ilvStrobe_t strobe;
  logic [1:0] jLow;

  ilv_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .nCouples(nCouples),
    .strobe(strobe), .jLow(jLow)
  );

  ilv_datapath #(.AW(AW), .PMAX(PMAX), .P2MIN(P2MIN), .P4MIN(P4MIN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .jLow(jLow),
    .nCouples(nCouples), .stepP0(stepP0),
    .offs0(offs0), .offs1(offs1), .offs2(offs2), .offs3(offs3),
    .validOut(validOut), .addrOut(addrOut), .swapOut(swapOut),
    .rowOut(rowOut), .bankIdx(bankIdx)
  );
endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
  parameter int AW    = 12,
  parameter int PMAX  = 4,
  parameter int P2MIN = 192,
  parameter int P4MIN = 480,
  localparam int LW   = $clog2(PMAX)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      nCouples,
  input logic               validOut,
  input logic [AW-1:0]      addrOut,
  input logic               swapOut,
  input logic [AW-1:0]      rowOut,
  input logic [PMAX*LW-1:0] bankIdx
);
  int unsigned pChk, segChk;
  logic [PMAX-1:0] laneMask;

  always_comb begin
    pChk = (int'(nCouples) >= P4MIN) ? 4 : (int'(nCouples) >= P2MIN) ? 2 : 1;
    segChk = int'(nCouples) / pChk;
    laneMask = '0;
    for (int k = 0; k < PMAX; k++)
      if (k < int'(pChk)) laneMask[bankIdx[k*LW +: LW]] = 1'b1;
  end

  // R1
  a_r1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    validOut |-> addrOut < nCouples);
  // R3
  a_r3_swap_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    validOut && $past(validOut) |-> swapOut != $past(swapOut));
  a_r3_first_even: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(validOut) |-> !swapOut);
  // R5
  a_r5_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    validOut |-> int'(rowOut) < int'(segChk));
  a_r5_recompose: assert property (@(posedge clk) disable iff (!rst_n)
    validOut |-> int'(addrOut) == int'(rowOut) + int'(bankIdx[LW-1:0]) * int'(segChk));
  // R6
  a_r6_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    validOut |-> $countones(laneMask) == int'(pChk));
endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.AW(AW), .PMAX(PMAX), .P2MIN(P2MIN), .P4MIN(P4MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .nCouples(nCouples), .validOut(validOut),
  .addrOut(addrOut), .swapOut(swapOut), .rowOut(rowOut), .bankIdx(bankIdx)
);

// File: tb/test_ilv_addr_gen.sv
`timescale 1ns/1ps
module test_ilv_addr_gen;
  localparam int AW = 12;
  localparam int PMAX = 4;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] nCouples = '0, stepP0 = '0, offs0 = '0, offs1 = '0, offs2 = '0, offs3 = '0;
  logic validOut, swapOut;
  logic [AW-1:0] addrOut, rowOut;
  logic [PMAX*LW-1:0] bankIdx;

  int nTests = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  ilv_addr_gen i_ilv_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .nCouples(nCouples), .stepP0(stepP0),
    .offs0(offs0), .offs1(offs1), .offs2(offs2), .offs3(offs3),
    .validOut(validOut), .addrOut(addrOut), .swapOut(swapOut),
    .rowOut(rowOut), .bankIdx(bankIdx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Run one frame; optionally pulse start again (with a new step) at couple busyAt.
  task automatic runFrame(input int n, input int p0, input int c0, input int c1,
                          input int c2, input int c3, input int busyAt);
    int c[4];
    int p, seg, lat;
    longint e;
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
    p = (n >= 480) ? 4 : (n >= 192) ? 2 : 1;
    seg = n / p;
    @(negedge clk);
    nCouples = AW'(n); stepP0 = AW'(p0);
    offs0 = AW'(c0); offs1 = AW'(c1); offs2 = AW'(c2); offs3 = AW'(c3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!validOut && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk("R2 latency", lat, 2);
    for (int j = 0; j < n; j++) begin
      int q;
      e = (longint'(p0) * j + c[j % 4]) % n;
      q = int'(e) / seg;
      chk("R2 valid", int'(validOut), 1);
      chk("R1 addr", int'(addrOut), int'(e));
      chk("R3 swap", int'(swapOut), j % 2);
      chk("R5 row", int'(rowOut), int'(e) - q * seg);
      for (int k = 0; k < PMAX; k++)
        chk("R6 bank", int'(bankIdx[k*LW +: LW]), (q + k) % p);
      if (j == busyAt) begin
        // R7: second start while busy, with a different step constant
        start = 1'b1;
        stepP0 = AW'((p0 + 1) % n);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R2 valid falls", int'(validOut), 0);
    for (int w = 0; w < 4; w++) begin
      chk("R7 no restart", int'(validOut), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 valid", int'(validOut), 0);
    chk("R8 addr", int'(addrOut), 0);
    chk("R8 swap", int'(swapOut), 0);
    chk("R8 row", int'(rowOut), 0);
    chk("R8 bank", int'(bankIdx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 idle", int'(validOut), 0);
    // R4: P=1 sizes
    runFrame(24, 5, 1, 13, 1, 13, -1);
    runFrame(180, 179, 1, 91, 178, 0, -1);
    // R4: P=2 sizes, including a restart attempt mid-frame (R7)
    runFrame(192, 11, 1, 97, 191, 49, 7);
    runFrame(240, 13, 1, 181, 1, 181, -1);
    // R4: P=4 sizes
    runFrame(480, 53, 479, 241, 1, 361, -1);
    runFrame(960, 29, 1, 481, 959, 721, 500);
    runFrame(2400, 53, 1, 1263, 2399, 1563, -1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule